// File: doc/BRIEF.md
# Five-Stage In-Order Pipelined Core

This block is a compact in-order processor core split into fetch, decode/register read, execute, memory access and write-back stages. Each stage boundary is a register that carries the opcode and destination register forward, so every stage decodes its own controls locally. The core holds an eight-entry register file, a word-addressed instruction memory and a word-addressed data memory. It executes register add and NAND, add-immediate, load, store, branch-if-equal, no-op and halt.

The core does not forward results and has no hazard interlock. Software must keep enough independent instructions or no-ops between a producer and any consumer of its result. Before reset is released, a preload port fills both memories. A debug read port exposes any register, and the PC, a retired-instruction count and a halted flag are brought out as outputs.

Top module: `pipe5_core`

## Requirements
- R1: Fetch reads one instruction per cycle at the word index held in the PC, and the PC steps by one. When a program's last instruction is the N-th one and no branch is taken, halted rises exactly N+4 clock edges after reset is released.
- R2: An instruction word is opcode[31:29], source A[28:26], source B[25:23], destination[22:20] and a signed 16-bit immediate[15:0]. The opcodes are 0 add, 1 nand, 2 add-immediate, 3 load, 4 store, 5 branch-if-equal, 6 halt and 7 no-op. Every register-writing instruction writes the destination field.
- R3: Add (opcode 0) writes A+B to the destination register, and nand (opcode 1) writes the bitwise inverse of A AND B, both modulo 2^32.
- R4: Add-immediate (opcode 2) writes A plus the sign-extended immediate.
- R5: Load (opcode 3) and store (opcode 4) use A plus the sign-extended immediate as the data address, and only its low address bits select a word, so addresses wrap. A load writes that word to the destination register. A store writes register B to it.
- R6: Branch-if-equal (opcode 5) is taken when registers A and B are equal. A taken branch sends the PC to its own address+1+immediate, and the three instructions fetched after it have no architectural effect. A branch that is not taken changes nothing.
- R7: A decoded halt stops fetch and freezes the PC at its own address+1. Halted rises when the halt reaches write-back and then stays high. A halt squashed by a taken branch has no effect.
- R8: The retired count rises by one for each instruction other than a no-op that reaches write-back, halt included. Squashed instructions and no-ops are not counted.
- R9: While reset is asserted, the PC, all registers, the retired count and halted read as zero.
- R10: Register writes take effect at the end of write-back, with no forwarding. An instruction placed three slots after its producer reads the old value, and one placed four slots after reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of PC, pipeline, registers and counters |
| prog_we | input | 1 | Preload write strobe |
| prog_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| prog_addr | input | PAW | Preload word address |
| prog_data | input | 32 | Preload word |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the selected register |
| pc | output | 32 | Current fetch index |
| retired | output | 32 | Retired-instruction count |
| halted | output | 1 | High once a halt has reached write-back |

## Verification
A wrong pipeline register shows up as a register value or memory word that differs from a sequential execution of the same program. The mismatch is visible on the debug port as soon as the program halts, a few dozen cycles after reset. A broken branch squash or halt stop shows as an extra retired count, a stray register write or a PC off by one at the halt. A broken fetch step or latency moves the edge on which halted rises, so the exact N+4 timing check catches it. Random programs are compared against a bench instruction-set model after every run, so an arithmetic or address error surfaces within one program.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_NAND = 3'd1, OP_ADDI = 3'd2, OP_LOAD = 3'd3,
    OP_STORE = 3'd4, OP_BEQ = 3'd5, OP_HALT = 3'd6, OP_NOOP = 3'd7
  } opcode_e;

  localparam logic [XLEN-1:0] NOOP_WORD = {OP_NOOP, 29'd0};

  typedef struct packed {
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] pc1;
  } ifid_t;

  typedef struct packed {
    opcode_e         op;
    logic [2:0]      dest;
    logic [XLEN-1:0] va;
    logic [XLEN-1:0] vb;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] pc1;
  } idex_t;

  typedef struct packed {
    opcode_e         op;
    logic [2:0]      dest;
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] vb;
    logic [XLEN-1:0] target;
    logic            eq;
  } exmem_t;

  typedef struct packed {
    opcode_e         op;
    logic [2:0]      dest;
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] ldata;
  } memwb_t;

  localparam ifid_t  IFID_NOP  = '{instr: NOOP_WORD, default: '0};
  localparam idex_t  IDEX_NOP  = '{op: OP_NOOP, default: '0};
  localparam exmem_t EXMEM_NOP = '{op: OP_NOOP, default: '0};
  localparam memwb_t MEMWB_NOP = '{op: OP_NOOP, default: '0};

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input opcode_e op,
      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [XLEN-1:0] imm);
    case (op)
      OP_ADD:  return a + b;
      OP_NAND: return ~(a & b);
      default: return a + imm;
    endcase
  endfunction

  function automatic logic writes_reg(input opcode_e op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_ADDI) || (op == OP_LOAD);
  endfunction
endpackage

// File: rtl/p5_mem.sv
module p5_mem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
  parameter int NREG = 8,
  parameter int WIDTH = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RAW-1:0]   waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [RAW-1:0]   ra_addr,
  output logic [WIDTH-1:0] ra_data,
  input  logic [RAW-1:0]   rb_addr,
  output logic [WIDTH-1:0] rb_data,
  input  logic [RAW-1:0]   dbg_addr,
  output logic [WIDTH-1:0] dbg_data
);
  logic [WIDTH-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs_q[g] <= '0;
      else if (we && waddr == RAW'(g)) regs_q[g] <= wdata;
    end
  end

  assign ra_data  = regs_q[ra_addr];
  assign rb_data  = regs_q[rb_addr];
  assign dbg_data = regs_q[dbg_addr];
endmodule

// File: rtl/p5_exec.sv
module p5_exec
  import pipe5_pkg::*;
(
  input  idex_t  idex,
  output exmem_t exmem
);
  always_comb begin
    exmem.op     = idex.op;
    exmem.dest   = idex.dest;
    exmem.alu    = alu_calc(idex.op, idex.va, idex.vb, idex.imm);
    exmem.vb     = idex.vb;
    exmem.target = idex.pc1 + idex.imm;
    exmem.eq     = (idex.va == idex.vb);
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int DAW = $clog2(DMEM_DEPTH),
  localparam int PAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic            prog_dmem,
  input  logic [PAW-1:0]  prog_addr,
  input  logic [31:0]     prog_data,
  input  logic [2:0]      dbg_sel,
  output logic [31:0]     dbg_data,
  output logic [31:0]     pc,
  output logic [31:0]     retired,
  output logic            halted
);
  logic [XLEN-1:0] pc_q, retired_q;
  logic            stop_q, halted_q;
  ifid_t           ifid_q;
  idex_t           idex_q, idex_d;
  exmem_t          exmem_q, exmem_d;
  memwb_t          memwb_q, memwb_d;

  // named internal events
  logic            branch_taken, halt_in_dec, fetch_en, rf_we, dmem_we;
  logic [XLEN-1:0] fetch_word, ra_val, rb_val, ld_word, rf_wdata, dmem_wdata;
  logic [DAW-1:0]  dmem_waddr;
  opcode_e         dec_op;

  assign dec_op       = opcode_e'(ifid_q.instr[31:29]);
  assign branch_taken = (exmem_q.op == OP_BEQ) && exmem_q.eq;
  assign halt_in_dec  = (dec_op == OP_HALT);
  assign fetch_en     = !stop_q && !halt_in_dec;

  p5_mem #(.DEPTH(IMEM_DEPTH), .WIDTH(XLEN)) u_imem (
    .clk(clk), .we(prog_we && !prog_dmem), .waddr(prog_addr[IAW-1:0]),
    .wdata(prog_data), .raddr(pc_q[IAW-1:0]), .rdata(fetch_word));

  p5_regfile #(.NREG(8), .WIDTH(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(memwb_q.dest), .wdata(rf_wdata),
    .ra_addr(ifid_q.instr[28:26]), .ra_data(ra_val),
    .rb_addr(ifid_q.instr[25:23]), .rb_data(rb_val),
    .dbg_addr(dbg_sel), .dbg_data(dbg_data));

  always_comb begin
    idex_d.op   = dec_op;
    idex_d.dest = ifid_q.instr[22:20];
    idex_d.va   = ra_val;
    idex_d.vb   = rb_val;
    idex_d.imm  = sext16(ifid_q.instr[15:0]);
    idex_d.pc1  = ifid_q.pc1;
  end

  p5_exec u_exec (.idex(idex_q), .exmem(exmem_d));

  assign dmem_we    = (prog_we && prog_dmem) || (exmem_q.op == OP_STORE);
  assign dmem_waddr = (prog_we && prog_dmem) ? prog_addr[DAW-1:0] : exmem_q.alu[DAW-1:0];
  assign dmem_wdata = (prog_we && prog_dmem) ? prog_data : exmem_q.vb;

  p5_mem #(.DEPTH(DMEM_DEPTH), .WIDTH(XLEN)) u_dmem (
    .clk(clk), .we(dmem_we), .waddr(dmem_waddr), .wdata(dmem_wdata),
    .raddr(exmem_q.alu[DAW-1:0]), .rdata(ld_word));

  always_comb begin
    memwb_d.op    = exmem_q.op;
    memwb_d.dest  = exmem_q.dest;
    memwb_d.alu   = exmem_q.alu;
    memwb_d.ldata = ld_word;
  end

  assign rf_we    = writes_reg(memwb_q.op);
  assign rf_wdata = (memwb_q.op == OP_LOAD) ? memwb_q.ldata : memwb_q.alu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q      <= '0;
      ifid_q    <= IFID_NOP;
      idex_q    <= IDEX_NOP;
      exmem_q   <= EXMEM_NOP;
      memwb_q   <= MEMWB_NOP;
      stop_q    <= 1'b0;
      halted_q  <= 1'b0;
      retired_q <= '0;
    end else begin
      memwb_q <= memwb_d;
      if (branch_taken) begin
        pc_q    <= exmem_q.target;
        ifid_q  <= IFID_NOP;
        idex_q  <= IDEX_NOP;
        exmem_q <= EXMEM_NOP;
        stop_q  <= 1'b0;
      end else begin
        idex_q  <= idex_d;
        exmem_q <= exmem_d;
        if (fetch_en) begin
          ifid_q <= '{instr: fetch_word, pc1: pc_q + 1'b1};
          pc_q   <= pc_q + 1'b1;
        end else begin
          ifid_q <= IFID_NOP;
        end
        if (halt_in_dec) stop_q <= 1'b1;
      end
      if (memwb_q.op == OP_HALT) halted_q <= 1'b1;
      if (memwb_q.op != OP_NOOP) retired_q <= retired_q + 1'b1;
    end
  end

  assign pc      = pc_q;
  assign retired = retired_q;
  assign halted  = halted_q;

  logic [XLEN-1:0] tgt_w;
  assign tgt_w = exmem_q.target;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en && !branch_taken |=> pc_q == $past(pc_q) + 32'd1); // R1
  AST_BRANCH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |=> pc_q == $past(tgt_w)); // R6
  AST_BRANCH_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |=> (dec_op == OP_NOOP && idex_q.op == OP_NOOP && exmem_q.op == OP_NOOP)); // R6
  AST_FETCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !branch_taken |=> $stable(pc_q)); // R7
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q); // R7
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (retired_q == $past(retired_q) || retired_q == $past(retired_q) + 32'd1)); // R8
  AST_NOOP_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    memwb_q.op == OP_NOOP |=> $stable(retired_q)); // R8
endmodule

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0, prog_dmem = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [2:0]  dbg_sel = '0;
  logic [31:0] dbg_data, pc, retired;
  logic        halted;

  pipe5_core dut (.clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_dmem(prog_dmem),
    .prog_addr(prog_addr), .prog_data(prog_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
    .pc(pc), .retired(retired), .halted(halted));

  always #4 clk = ~clk;  // 125 MHz

  int n_checks = 0, n_fail = 0, total_cyc = 0;
  logic [31:0] prog_m [64];
  logic [31:0] dinit_m [64];
  logic [31:0] reg_m [8];
  logic [31:0] mem_m [64];

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", total_cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int a, input int b, input int d,
                                      input int imm);
    return {op[2:0], a[2:0], b[2:0], d[2:0], 4'd0, imm[15:0]};
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic void clear_prog();
    for (int i = 0; i < 64; i++) prog_m[i] = enc(7, 0, 0, 0, 0);
  endfunction

  // sequential model of the instruction set (R2..R8)
  task automatic iss(output int ret, output logic [31:0] fpc);
    int p = 0;
    ret = 0;
    fpc = 0;
    for (int i = 0; i < 8; i++) reg_m[i] = 0;
    for (int i = 0; i < 64; i++) mem_m[i] = dinit_m[i];
    for (int step = 0; step < 500; step++) begin
      logic [31:0] w, ea;
      w  = prog_m[p[5:0]];
      ea = reg_m[w[28:26]] + sx(w[15:0]);
      if (w[31:29] != 3'd7) ret++;
      case (w[31:29])
        3'd0: reg_m[w[22:20]] = reg_m[w[28:26]] + reg_m[w[25:23]];
        3'd1: reg_m[w[22:20]] = ~(reg_m[w[28:26]] & reg_m[w[25:23]]);
        3'd2: reg_m[w[22:20]] = ea;
        3'd3: reg_m[w[22:20]] = mem_m[ea[5:0]];
        3'd4: mem_m[ea[5:0]] = reg_m[w[25:23]];
        3'd5: if (reg_m[w[28:26]] == reg_m[w[25:23]]) p = p + int'(sx(w[15:0]));
        3'd6: begin fpc = p + 1; return; end
        default: ;
      endcase
      p++;
    end
  endtask

  task automatic load_all();
    rst_n = 1'b0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_dmem = (i >= 64); prog_addr = 6'(i % 64);
      prog_data = (i >= 64) ? dinit_m[i-64] : prog_m[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic read_reg(input int r, output logic [31:0] v);
    dbg_sel = 3'(r);
    #1 v = dbg_data;
  endtask

  task automatic compare_iss(input string tag);
    int ret; logic [31:0] fpc, v;
    iss(ret, fpc);
    for (int r = 0; r < 8; r++) begin
      read_reg(r, v);
      check({tag, " register"}, v, reg_m[r]);
    end
    check("R8 retired count", retired, 32'(ret));
    check("R7 pc after halt", pc, fpc);
    check("R7 halted", {31'd0, halted}, 32'd1);
  endtask

  initial begin
    int cyc; logic [31:0] v;
    for (int i = 0; i < 64; i++) dinit_m[i] = 32'hCAFE_0000 + 32'(i);

    // R1 latency, R3 nand, R4 addi
    clear_prog();
    prog_m[0] = enc(2, 0, 0, 1, 5);
    prog_m[1] = enc(2, 0, 0, 2, -9);
    prog_m[2] = enc(1, 0, 0, 3, 0);
    prog_m[3] = enc(6, 0, 0, 0, 0);
    load_all();
    check("R9 pc in reset", pc, 32'd0);
    check("R9 retired in reset", retired, 32'd0);
    check("R9 halted in reset", {31'd0, halted}, 32'd0);
    run(cyc);
    check("R1 cycles to halt N+4", 32'(cyc), 32'd8);
    read_reg(1, v); check("R4 addi positive", v, 32'd5);
    read_reg(2, v); check("R4 addi negative", v, 32'hFFFF_FFF7);
    read_reg(3, v); check("R3 nand of zeros", v, 32'hFFFF_FFFF);

    // R10 no forwarding; R9 reset clears registers left by the previous run
    clear_prog();
    prog_m[0] = enc(2, 0, 0, 1, 3);
    prog_m[3] = enc(0, 1, 1, 2, 0);
    prog_m[4] = enc(0, 1, 1, 3, 0);
    prog_m[5] = enc(6, 0, 0, 0, 0);
    load_all();
    read_reg(1, v); check("R9 register cleared in reset", v, 32'd0);
    read_reg(3, v); check("R9 register cleared in reset", v, 32'd0);
    run(cyc);
    read_reg(2, v); check("R10 three slots reads old value", v, 32'd0);
    read_reg(3, v); check("R10 four slots reads new value", v, 32'd6);

    // R6 taken branch squashes three younger instructions
    clear_prog();
    prog_m[0] = enc(2, 0, 0, 1, 1);
    prog_m[4] = enc(5, 0, 0, 0, 3);
    prog_m[5] = enc(2, 0, 0, 2, 11);
    prog_m[6] = enc(2, 0, 0, 3, 12);
    prog_m[7] = enc(2, 0, 0, 4, 13);
    prog_m[8] = enc(6, 0, 0, 0, 0);
    load_all();
    run(cyc);
    read_reg(2, v); check("R6 squashed slot 1", v, 32'd0);
    read_reg(4, v); check("R6 squashed slot 3", v, 32'd0);
    check("R8 squashed not counted", retired, 32'd3);
    check("R6 pc at target halt", pc, 32'd9);

    // R7 halt squashed by taken branch
    clear_prog();
    prog_m[0] = enc(5, 0, 0, 0, 1);
    prog_m[1] = enc(6, 0, 0, 0, 0);
    prog_m[2] = enc(2, 0, 0, 5, 21);
    prog_m[3] = enc(6, 0, 0, 0, 0);
    load_all();
    run(cyc);
    read_reg(5, v); check("R7 squashed halt ignored", v, 32'd21);
    check("R7 pc after real halt", pc, 32'd4);
    check("R8 retired count", retired, 32'd3);

    // R5 store, load, negative offset wrap
    clear_prog();
    prog_m[0] = enc(2, 0, 0, 1, 10);
    prog_m[4] = enc(4, 1, 1, 0, 2);
    prog_m[5] = enc(3, 1, 0, 2, 2);
    prog_m[6] = enc(3, 1, 0, 3, -10);
    prog_m[7] = enc(3, 0, 0, 4, -1);
    prog_m[8] = enc(6, 0, 0, 0, 0);
    load_all();
    run(cyc);
    read_reg(2, v); check("R5 load after store", v, 32'd10);
    read_reg(3, v); check("R5 negative offset", v, 32'hCAFE_0000);
    read_reg(4, v); check("R5 address wrap", v, 32'hCAFE_003F);
    compare_iss("R5");

    // constrained random programs vs sequential model (R2..R8)
    void'($urandom(32'd1234));
    for (int t = 0; t < 25; t++) begin
      clear_prog();
      for (int i = 0; i < 64; i++) dinit_m[i] = $urandom;
      for (int k = 0; k < 11; k++) begin
        int op, imm, lim;
        op  = $urandom % 6;
        imm = int'($urandom % 65536) - 32768;
        if (op == 2) imm = int'($urandom % 41) - 20;
        if (op == 5) begin
          lim = 44 - 4 * k - 1;
          imm = $urandom % 9;
          if (imm > lim) imm = lim;
        end
        prog_m[4*k] = enc(op, $urandom % 8, (op == 5 && t % 2 == 0) ? 0 : $urandom % 8,
                          $urandom % 8, imm);
      end
      prog_m[44] = enc(6, 0, 0, 0, 0);
      load_all();
      run(cyc);
      compare_iss("R3 R4 R5 R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule